// File: doc/BRIEF.md
# System Clock Rate Selector

This block sets the rate at which the processor core advances. It runs on the fastest clock in the system: the multiplied clock, which is four times the crystal rate and is provided to it ready-made. It gives the core a single-cycle clock-enable strobe. The strobe fires on every fast cycle (times-four), on every second fast cycle (times-two), once per crystal period (divide-by-1), or once per `SLOW_DIV` crystal periods (low-power divide-by-1024 with the default).

Software writes all configuration fields in one register write, at any time:

- a two-bit divide code;
- a multiplier enable;
- a times-four/times-two select;
- a switchback enable.

A rate change waits for the end of the divided period that is running, so the core never sees a shortened period. The one exception is switchback. While the slow rate is selected and switchback is enabled, any pending enabled external interrupt drops the block straight back to divide-by-1. The stored divide code is rewritten to the divide-by-1 value at the same time.

Top module: `sysclk_div_ctrl`

## Requirements
- R1: After any reset the stored divide code reads 10, the active mode is divide-by-1 (mode code 2), the multiplier and switchback are disabled, and the clock enable is high in the first cycle after reset is released.
- R2: `mode_o` reports the active rate as 0 = times-four (strobe period 1 fast cycle), 1 = times-two (period 2), 2 = divide-by-1 (period 4), 3 = slow (period 4*SLOW_DIV).
- R3: Divide code 00 selects times-four when the multiplier is enabled and the select bit is 1, times-two when it is enabled and the select bit is 0, and divide-by-1 when the multiplier is disabled.
- R4: Divide codes 01 and 10 both select divide-by-1, whatever the multiplier bits are.
- R5: Divide code 11 selects the slow rate, whatever the multiplier bits are, with one strobe every 4*SLOW_DIV fast cycles.
- R6: A write updates the divide read-back `div_rd_o` in the cycle after the write.
- R7: The active mode changes only on the cycle after a strobe. After a write, the next strobe still comes at the end of the period that was running, and the new period starts from that strobe.
- R8: If the stored code is 11, switchback is enabled, and any `irq_pend_i` bit is high at a clock edge, then in the next cycle `div_rd_o` reads 10, `mode_o` is 2 and the clock enable is high. Strobes then follow every 4 cycles. Switchback wins over a write in the same cycle.
- R9: `irq_pend_i` has no effect when switchback is disabled or when the stored code is not 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Multiplied clock, four times the crystal rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_div_i | input | 2 | Divide code to write |
| wr_mult_en_i | input | 1 | Multiplier enable to write |
| wr_x4_i | input | 1 | Times-four (1) or times-two (0) select to write |
| wr_swb_i | input | 1 | Switchback enable to write |
| irq_pend_i | input | IRQ_W | Pending enabled external interrupt requests |
| clk_en_o | output | 1 | Core clock-enable strobe |
| div_rd_o | output | 2 | Read-back of the stored divide code |
| mode_o | output | 2 | Active rate code |

## Verification
Results arrive on a fixed schedule:

- Read-back and switchback effects appear in the cycle after the edge that samples the write or the interrupt. The bench drives on the falling edge and checks at the next falling edge.
- A rate change appears only after the strobe that closes the running period. The bench therefore waits for `mode_o` to reach the expected code before it measures anything. It then counts fast cycles between two strobes and compares the count with the arithmetic period for that mode.
- The boundary test starts its count at a slow-rate strobe and writes a new code partway through. It then expects the next strobe exactly 4*SLOW_DIV cycles after the first.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
  typedef enum logic [1:0] {
    MODE_X4   = 2'd0,
    MODE_X2   = 2'd1,
    MODE_DIV1 = 2'd2,
    MODE_SLOW = 2'd3
  } ckdiv_mode_e;

  localparam logic [1:0] CODE_MULT = 2'b00;
  localparam logic [1:0] CODE_ONE  = 2'b10;
  localparam logic [1:0] CODE_SLOW = 2'b11;
endpackage

// File: rtl/ckdiv_cfg.sv
module ckdiv_cfg
  import ckdiv_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_div_i,
  input  logic             wr_mult_en_i,
  input  logic             wr_x4_i,
  input  logic             wr_swb_i,
  input  logic [IRQ_W-1:0] irq_pend_i,
  output logic [1:0]       div_o,
  output ckdiv_mode_e      req_mode_o,
  output logic             swb_hit_o
);
  logic [1:0] div_q;
  logic       mult_q, x4_q, swb_q;

  assign swb_hit_o = (div_q == CODE_SLOW) && swb_q && (|irq_pend_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= CODE_ONE;
      mult_q <= 1'b0;
      x4_q   <= 1'b0;
      swb_q  <= 1'b0;
    end else begin
      if (wr_en_i) begin
        mult_q <= wr_mult_en_i;
        x4_q   <= wr_x4_i;
        swb_q  <= wr_swb_i;
      end
      // hardware switchback beats a same-cycle write of the code
      if (swb_hit_o)    div_q <= CODE_ONE;
      else if (wr_en_i) div_q <= wr_div_i;
    end
  end

  always_comb begin
    unique case (div_q)
      CODE_SLOW: req_mode_o = MODE_SLOW;
      CODE_MULT: req_mode_o = !mult_q ? MODE_DIV1 : (x4_q ? MODE_X4 : MODE_X2);
      default:   req_mode_o = MODE_DIV1; // 01 aliases 10
    endcase
  end

  assign div_o = div_q;

  a_r8_switchback_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swb_hit_o |=> (div_q == CODE_ONE));
  a_r9_code_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q == CODE_SLOW && !swb_q && !wr_en_i) |=> (div_q == CODE_SLOW));
  a_r6_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !swb_hit_o) |=> (div_q == $past(wr_div_i)));
endmodule

// File: rtl/ckdiv_strobe.sv
module ckdiv_strobe
  import ckdiv_pkg::*;
#(
  parameter int SLOW_DIV = 1024
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  ckdiv_mode_e req_mode_i,
  input  logic        force_i,
  output logic        en_o,
  output ckdiv_mode_e mode_o
);
  localparam int XTAL_RATIO  = 4;
  localparam int SLOW_PERIOD = XTAL_RATIO * SLOW_DIV;
  localparam int CW          = $clog2(SLOW_PERIOD);

  function automatic logic [CW-1:0] last_of(ckdiv_mode_e m);
    unique case (m)
      MODE_X4:   last_of = CW'(0);
      MODE_X2:   last_of = CW'(1);
      MODE_DIV1: last_of = CW'(XTAL_RATIO - 1);
      default:   last_of = CW'(SLOW_PERIOD - 1);
    endcase
  endfunction

  logic [CW-1:0] cnt_q;
  ckdiv_mode_e   act_q;
  logic          wrap;

  assign wrap = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= MODE_DIV1;
    end else if (force_i) begin
      cnt_q <= '0;
      act_q <= MODE_DIV1;
    end else if (wrap) begin
      cnt_q <= last_of(req_mode_i);
      act_q <= req_mode_i;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign en_o   = wrap;
  assign mode_o = act_q;

  a_r7_mode_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> ($past(wrap) || $past(force_i)));
  a_r2_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_of(act_q));
  a_r8_force_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> (en_o && act_q == MODE_DIV1));
endmodule

// File: rtl/sysclk_div_ctrl.sv
module sysclk_div_ctrl
  import ckdiv_pkg::*;
#(
  parameter int IRQ_W    = 4,
  parameter int SLOW_DIV = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_div_i,
  input  logic             wr_mult_en_i,
  input  logic             wr_x4_i,
  input  logic             wr_swb_i,
  input  logic [IRQ_W-1:0] irq_pend_i,
  output logic             clk_en_o,
  output logic [1:0]       div_rd_o,
  output logic [1:0]       mode_o
);
  ckdiv_mode_e req_mode, act_mode;
  logic        swb_hit;

  ckdiv_cfg #(.IRQ_W(IRQ_W)) cfg_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_div_i     (wr_div_i),
    .wr_mult_en_i (wr_mult_en_i),
    .wr_x4_i      (wr_x4_i),
    .wr_swb_i     (wr_swb_i),
    .irq_pend_i   (irq_pend_i),
    .div_o        (div_rd_o),
    .req_mode_o   (req_mode),
    .swb_hit_o    (swb_hit)
  );

  ckdiv_strobe #(.SLOW_DIV(SLOW_DIV)) strobe_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_mode_i (req_mode),
    .force_i    (swb_hit),
    .en_o       (clk_en_o),
    .mode_o     (act_mode)
  );

  assign mode_o = act_mode;
endmodule

// File: tb/sysclk_div_ctrl_tb_top.sv
`timescale 1ns/1ps
module sysclk_div_ctrl_tb_top;
  localparam int IRQ_W    = 4;
  localparam int SLOW_DIV = 1024;
  localparam int SLOW_P   = 4 * SLOW_DIV;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0, wr_mult = 1'b0, wr_x4 = 1'b0, wr_swb = 1'b0;
  logic [1:0] wr_div = 2'b10;
  logic [IRQ_W-1:0] irq = '0;
  logic clk_en;
  logic [1:0] div_rd, mode;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sysclk_div_ctrl #(.IRQ_W(IRQ_W), .SLOW_DIV(SLOW_DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_div_i(wr_div),
    .wr_mult_en_i(wr_mult), .wr_x4_i(wr_x4), .wr_swb_i(wr_swb),
    .irq_pend_i(irq), .clk_en_o(clk_en), .div_rd_o(div_rd), .mode_o(mode)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] d, input logic me, input logic x4, input logic sw);
    wr_en = 1'b1; wr_div = d; wr_mult = me; wr_x4 = x4; wr_swb = sw;
    step();
    wr_en = 1'b0;
  endtask

  task automatic wait_mode(input int m);
    int n = 0;
    while (int'(mode) != m && n < 3 * SLOW_P) begin step(); n++; end
  endtask

  task automatic wait_strobe();
    int n = 0;
    while (!clk_en && n < 3 * SLOW_P) begin step(); n++; end
  endtask

  task automatic gap(output int n);
    n = 1;
    step();
    while (!clk_en && n < 3 * SLOW_P) begin step(); n++; end
  endtask

  function automatic int exp_mode(int d, int me, int x4);
    if (d == 3) return 3;
    if (d == 0 && me == 1) return (x4 == 1) ? 0 : 1;
    return 2;
  endfunction

  function automatic int exp_period(int m);
    case (m)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return SLOW_P;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int g;
    step(); step();
    // R1 reset state
    chk(div_rd == 2'b10, "R1 div", div_rd, 2);
    chk(mode == 2'd2, "R1 mode", mode, 2);
    chk(clk_en == 1'b1, "R1 en", clk_en, 1);
    rst_ni = 1'b1;
    chk(clk_en == 1'b1, "R1 first en", clk_en, 1);
    gap(g);
    chk(g == 4, "R1 period", g, 4);

    // R2..R6 sweep over all codes and multiplier bits
    for (int d = 0; d < 4; d++) begin
      for (int me = 0; me < 2; me++) begin
        for (int x4 = 0; x4 < 2; x4++) begin
          int em;
          string tag;
          em = exp_mode(d, me, x4);
          tag = (d == 3) ? "R5" : (d == 0) ? "R3" : "R4";
          cfg_write(2'(d), 1'(me), 1'(x4), 1'b0);
          chk(int'(div_rd) == d, "R6 readback", div_rd, d);
          wait_mode(em);
          chk(int'(mode) == em, tag, mode, em);
          wait_strobe();
          gap(g);
          chk(g == exp_period(em), "R2 period", g, exp_period(em));
        end
      end
    end

    // R7 change waits for the running slow period
    cfg_write(2'b11, 1'b0, 1'b0, 1'b0);
    wait_mode(3);
    wait_strobe();
    step();
    repeat (99) step();
    cfg_write(2'b10, 1'b0, 1'b0, 1'b0);
    g = 101;
    while (!clk_en && g < 3 * SLOW_P) begin step(); g++; end
    chk(g == SLOW_P, "R7 boundary", g, SLOW_P);
    chk(mode == 2'd3, "R7 mode held", mode, 3);
    step();
    chk(mode == 2'd2, "R7 mode new", mode, 2);
    gap(g);
    g++;
    chk(g == 5 || g == 4, "R7 next period", g, 4);

    // R8 switchback mid slow period
    cfg_write(2'b11, 1'b0, 1'b0, 1'b1);
    wait_mode(3);
    wait_strobe();
    repeat (50) step();
    irq = 4'b0100;
    step();
    irq = '0;
    chk(div_rd == 2'b10, "R8 div", div_rd, 2);
    chk(mode == 2'd2, "R8 mode", mode, 2);
    chk(clk_en == 1'b1, "R8 en", clk_en, 1);
    gap(g);
    chk(g == 4, "R8 period", g, 4);

    // R8 switchback beats a same-cycle write
    cfg_write(2'b11, 1'b0, 1'b0, 1'b1);
    wait_mode(3);
    irq = 4'b0001; wr_en = 1'b1; wr_div = 2'b00; wr_mult = 1'b1; wr_x4 = 1'b1; wr_swb = 1'b1;
    step();
    irq = '0; wr_en = 1'b0;
    chk(div_rd == 2'b10, "R8 priority", div_rd, 2);

    // R9 irq ignored without switchback enable
    cfg_write(2'b11, 1'b0, 1'b0, 1'b0);
    wait_mode(3);
    irq = '1;
    repeat (20) step();
    chk(div_rd == 2'b11, "R9 div kept", div_rd, 3);
    chk(mode == 2'd3, "R9 mode kept", mode, 3);
    irq = '0;

    // R9 irq ignored when code is not 11
    cfg_write(2'b10, 1'b0, 1'b0, 1'b1);
    wait_mode(2);
    wait_strobe();
    irq = '1;
    gap(g);
    chk(g == 4, "R9 period kept", g, 4);
    chk(div_rd == 2'b10, "R9 div not 11", div_rd, 2);
    irq = '0;

    // R1 reset during slow mode
    cfg_write(2'b11, 1'b1, 1'b1, 1'b1);
    wait_mode(3);
    rst_ni = 1'b0;
    step();
    chk(div_rd == 2'b10, "R1 rerst div", div_rd, 2);
    chk(mode == 2'd2, "R1 rerst mode", mode, 2);
    rst_ni = 1'b1;
    cfg_write(2'b00, 1'b0, 1'b1, 1'b0);
    wait_strobe();
    gap(g);
    chk(g == 4, "R1 mult off after reset", g, 4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule